// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block locates an entry in the chain of extended capability headers that sits above the 256-byte legacy region of a PCIe configuration space. Each header is one 32-bit word: a capability ID, a version and a pointer to the next header. Given a requested ID, the walker fetches headers one at a time through a configuration memory port with one cycle of read latency. It follows the next pointers until it finds a match or reaches the end of the chain. It then reports the byte offset of the match (0 when there is none) and the offset of the entry visited just before it.

ID 0 is reserved and never matches. A search for it runs to the last entry of the chain, so the reported previous offset is the tail, where a new capability would be linked in. In append mode the walker finds the tail in the same way and rewrites that header's next pointer with a supplied offset. It keeps the ID and the version.

Two guards prevent a corrupt chain from driving the walk off the map or trapping it in a loop. A pointer outside the legal window stops the walk with an error. A hop limit stops the walk with a timeout. Software or a neighbouring block uses a start/busy/done handshake, and the results hold until the next start.

Top module: `ecap_walker`

## Requirements
- R1: A header word is decoded as ID in bits [15:0], version in bits [19:16] and next offset in bits [31:20]. When a header's ID equals a nonzero requested ID, the result is found = that header's offset, prev = the offset visited before it (0 if the match is the first header), err = 0, timeout = 0.
- R2: Every walk begins with a read of offset 0x100. Each visited header costs exactly one read, and the walk follows next pointers in order.
- R3: If the first header word (at 0x100) is all zeros, the chain is empty: found = 0, prev = 0, exactly one read, and no write even in append mode.
- R4: When a header with next offset 0 is reached without a match, the result is found = 0 and prev = that header's offset.
- R5: A next offset below 0x100 or above 0xFF8 is not followed. The walk ends with err = 1, found = 0 and prev = the offset of the header holding the bad pointer, so no read ever leaves the window 0x100..0xFF8. 0xFF8 itself is legal.
- R6: Requested ID 0 never matches any header. The walk runs to the end of the chain and reports found = 0 and prev = the tail offset.
- R7: In append mode the requested ID is ignored and the walk behaves as the ID 0 search. At the tail the block performs one write to the tail's offset with bits [31:20] = new_next and bits [19:0] equal to the tail header as read. The results are found = 0 and prev = tail.
- R8: In append mode a new_next whose low two bits are not zero is rejected: no write, err = 1, found = 0, prev = tail.
- R9: If MAX_HOPS headers (default 1024) have been read and the last one still points onward, the walk ends with timeout = 1, err = 0, found = 0, prev = the last header's offset, after exactly MAX_HOPS reads.
- R10: start is accepted only while the block is idle. busy is high from the cycle after acceptance until the walk ends, and done pulses for one cycle with busy low. The results stay unchanged from done until the next accepted start, and a start raised while busy has no effect.
- R11: After reset, busy, done, found_off, prev_off, err, timeout, cfg_rd_en and cfg_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| req_id | input | 16 | Capability ID to search for (0 = locate tail) |
| append | input | 1 | Walk to the tail and relink its next pointer |
| new_next | input | 12 | Offset to store in the tail's next field when appending |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| found_off | output | 12 | Offset of matching header, 0 if none |
| prev_off | output | 12 | Offset of the entry visited before the result / tail |
| err | output | 1 | Illegal next pointer or misaligned append offset |
| timeout | output | 1 | Hop limit reached |
| cfg_rd_en | output | 1 | Config memory read strobe |
| cfg_wr_en | output | 1 | Config memory write strobe |
| cfg_addr | output | 12 | Config memory byte offset |
| cfg_wdata | output | 32 | Header word to write |
| cfg_rdata | input | 32 | Header word, valid the cycle after cfg_rd_en |

## Verification
A corrupted current-offset register shows up at the very next read strobe as a wrong cfg_addr, and in the final prev_off, so the bench counts the reads of every walk and checks the pointers it reports. A hop counter that drifts changes the number of reads before timeout, which a self-looping chain exposes after one walk of exactly MAX_HOPS reads. Errors in the header keep register or the alignment test appear in the single word written during append, and the bench reads that word back from its memory model as soon as done arrives. A result register that is reloaded while idle is caught within four cycles of done, and a start that leaks in while busy is caught in the same way.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int OFF_W  = 12;
    localparam int ID_W   = 16;
    localparam int VER_W  = 4;
    localparam int WORD_W = OFF_W + VER_W + ID_W;

    // First header lives just past the legacy region; the last legal header
    // start leaves room for one header plus one spare dword before the top.
    localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(256);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((1 << OFF_W) - 8);

    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } ecap_hdr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE
    } walk_st_t;

    typedef enum logic [2:0] {
        DEC_EMPTY,
        DEC_MATCH,
        DEC_END,
        DEC_BADPTR,
        DEC_HOP
    } hop_dec_t;

    typedef struct packed {
        logic [OFF_W-1:0] found;
        logic [OFF_W-1:0] prev;
        logic             err;
        logic             timeout;
    } walk_res_t;

    function automatic logic off_legal(input logic [OFF_W-1:0] off);
        return (off >= BASE_OFF) && (off <= LAST_OFF);
    endfunction

    function automatic logic dword_aligned(input logic [OFF_W-1:0] off);
        return off[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/ecap_hop_decide.sv
module ecap_hop_decide
    import ecap_pkg::*;
(
    input  logic             word_zero,
    input  logic             first,
    input  logic             probe,
    input  logic [ID_W-1:0]  hdr_id,
    input  logic [ID_W-1:0]  want_id,
    input  logic [OFF_W-1:0] hdr_next,
    output hop_dec_t         dec
);

    always_comb begin
        if (first && word_zero)
            dec = DEC_EMPTY;
        else if (!probe && (hdr_id == want_id))
            dec = DEC_MATCH;
        else if (hdr_next == '0)
            dec = DEC_END;
        else if (!off_legal(hdr_next))
            dec = DEC_BADPTR;
        else
            dec = DEC_HOP;
    end

endmodule

// File: rtl/ecap_hop_limit.sv
module ecap_hop_limit #(
    parameter int MAX_HOPS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic first,
    output logic last
);

    localparam int CNT_W = (MAX_HOPS > 1) ? $clog2(MAX_HOPS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_HOPS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign last  = (cnt == CNT_LAST);

    // R9: the controller must stop hopping once the limit is reached
    a_r9_no_hop_past_limit: assert property (@(posedge clk) disable iff (rst)
        inc |-> !last);

endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
    import ecap_pkg::*;
#(
    parameter int MAX_HOPS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ID_W-1:0]   req_id,
    input  logic              append,
    input  logic [OFF_W-1:0]  new_next,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  found_off,
    output logic [OFF_W-1:0]  prev_off,
    output logic              err,
    output logic              timeout,
    output logic              cfg_rd_en,
    output logic              cfg_wr_en,
    output logic [OFF_W-1:0]  cfg_addr,
    output logic [WORD_W-1:0] cfg_wdata,
    input  logic [WORD_W-1:0] cfg_rdata
);

    walk_st_t                   st;
    logic [OFF_W-1:0]           cur_q;
    logic [OFF_W-1:0]           prev_q;
    logic [ID_W-1:0]            id_q;
    logic                       app_q;
    logic [OFF_W-1:0]           nn_q;
    logic [VER_W+ID_W-1:0]      keep_q;
    walk_res_t                  res_q;
    logic                       done_q;

    ecap_hdr_t hdr;
    hop_dec_t  dec;
    logic      first, last, hop_clr, hop_inc;

    assign hdr = ecap_hdr_t'(cfg_rdata);

    ecap_hop_decide u_decide (
        .word_zero (cfg_rdata == '0),
        .first     (first),
        .probe     (app_q || (id_q == '0)),
        .hdr_id    (hdr.id),
        .want_id   (id_q),
        .hdr_next  (hdr.nxt),
        .dec       (dec)
    );

    ecap_hop_limit #(.MAX_HOPS(MAX_HOPS)) u_limit (
        .clk   (clk),
        .rst   (rst),
        .clr   (hop_clr),
        .inc   (hop_inc),
        .first (first),
        .last  (last)
    );

    assign hop_clr = (st == ST_IDLE) && start;
    assign hop_inc = (st == ST_EVAL) && (dec == DEC_HOP) && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur_q  <= '0;
            prev_q <= '0;
            id_q   <= '0;
            app_q  <= 1'b0;
            nn_q   <= '0;
            keep_q <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        id_q   <= req_id;
                        app_q  <= append;
                        nn_q   <= new_next;
                        cur_q  <= BASE_OFF;
                        prev_q <= '0;
                        res_q  <= '0;
                        st     <= ST_READ;
                    end
                end
                ST_READ: st <= ST_EVAL;
                ST_EVAL: begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                    case (dec)
                        DEC_EMPTY: res_q <= '0;
                        DEC_MATCH: begin
                            res_q.found <= cur_q;
                            res_q.prev  <= prev_q;
                        end
                        DEC_END: begin
                            res_q.prev <= cur_q;
                            if (app_q) begin
                                if (!dword_aligned(nn_q)) begin
                                    res_q.err <= 1'b1;
                                end else begin
                                    keep_q <= {hdr.ver, hdr.id};
                                    st     <= ST_WRITE;
                                    done_q <= 1'b0;
                                end
                            end
                        end
                        DEC_BADPTR: begin
                            res_q.prev <= cur_q;
                            res_q.err  <= 1'b1;
                        end
                        default: begin
                            if (last) begin
                                res_q.prev    <= cur_q;
                                res_q.timeout <= 1'b1;
                            end else begin
                                prev_q <= cur_q;
                                cur_q  <= hdr.nxt;
                                st     <= ST_READ;
                                done_q <= 1'b0;
                            end
                        end
                    endcase
                end
                ST_WRITE: begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign found_off = res_q.found;
    assign prev_off  = res_q.prev;
    assign err       = res_q.err;
    assign timeout   = res_q.timeout;
    assign cfg_rd_en = (st == ST_READ);
    assign cfg_wr_en = (st == ST_WRITE);
    assign cfg_addr  = cur_q;
    assign cfg_wdata = {nn_q, keep_q};

    // R2: the first read of every walk targets the base of the chain
    a_r2_first_read_base: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cfg_rd_en && cfg_addr == BASE_OFF));

    // R5: no read ever leaves the legal header window
    a_r5_read_in_window: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_en |-> ((cfg_addr >= BASE_OFF) && (cfg_addr <= LAST_OFF)));

    // R7: the rewritten tail keeps the ID and version that were just read
    a_r7_keep_id_ver: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (cfg_wdata[VER_W+ID_W-1:0] == $past(cfg_rdata[VER_W+ID_W-1:0])));

    // R8: only dword-aligned next pointers are ever written
    a_r8_write_aligned: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (cfg_wdata[ID_W+VER_W+1:ID_W+VER_W] == 2'b00));

    // R10: done is a pulse seen with busy low, and strobes never overlap
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !$past(done)));

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_rd_en, cfg_wr_en, done}));

    // R10: results hold while idle until a new start is accepted
    a_r10_results_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(found_off) && $stable(prev_off)
                               && $stable(err) && $stable(timeout)));

endmodule

// File: tb/tb_ecap_walker.sv
module tb_ecap_walker;

    localparam int MAX_HOPS = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] req_id = '0;
    logic        append = 1'b0;
    logic [11:0] new_next = '0;
    logic        busy, done, err, timeout;
    logic [11:0] found_off, prev_off;
    logic        cfg_rd_en, cfg_wr_en;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;

    always #10 clk = ~clk;

    ecap_walker #(.MAX_HOPS(MAX_HOPS)) dut (
        .clk(clk), .rst(rst), .start(start), .req_id(req_id),
        .append(append), .new_next(new_next), .busy(busy), .done(done),
        .found_off(found_off), .prev_off(prev_off), .err(err),
        .timeout(timeout), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // Configuration memory model: one cycle read latency
    logic [31:0] mem [1024];
    logic        tb_we = 1'b0;
    logic [11:0] tb_a = '0;
    logic [31:0] tb_d = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
            cfg_rdata <= '0;
        end else begin
            if (tb_we) mem[tb_a[11:2]] <= tb_d;
            if (cfg_wr_en) mem[cfg_addr[11:2]] <= cfg_wdata;
            if (cfg_rd_en) cfg_rdata <= mem[cfg_addr[11:2]];
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    int drv_cnt = 0;
    int mon_cnt = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    int cyc     = 0;

    typedef struct packed {
        logic [11:0] found;
        logic [11:0] prev;
        logic        err;
        logic        to;
        logic [31:0] reads;
        logic [31:0] writes;
    } exp_item_t;

    exp_item_t sb_q[$];
    string     tag_q[$];

    function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ver,
                                        input logic [11:0] nxt);
        return {nxt, ver, id};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic put(input logic [11:0] off, input logic [31:0] word);
        @(negedge clk);
        tb_we = 1'b1; tb_a = off; tb_d = word;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    // Driver: push expectation, launch, optionally poke start while busy
    task automatic run_op(input string tag, input logic [15:0] id, input logic app,
                          input logic [11:0] nn, input logic [11:0] ef,
                          input logic [11:0] ep, input logic ee, input logic et,
                          input int er, input int ew, input bit poke);
        exp_item_t it;
        it.found = ef; it.prev = ep; it.err = ee; it.to = et;
        it.reads = er; it.writes = ew;
        sb_q.push_back(it);
        tag_q.push_back(tag);
        drv_cnt++;
        @(negedge clk);
        req_id = id; append = app; new_next = nn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_id = 16'h0001; append = 1'b1; new_next = 12'h400; start = 1'b1;
            @(negedge clk);
            start = 1'b0; append = 1'b0;
        end
        wait (mon_cnt == drv_cnt);
        repeat (4) @(negedge clk);
        check({tag, " R10 found held"}, {20'h0, found_off}, {20'h0, ef});
        check({tag, " R10 prev held"},  {20'h0, prev_off},  {20'h0, ep});
    endtask

    // Monitor: scoreboard compare on each done pulse
    always @(negedge clk) begin
        if (rst) begin
            rd_seen = 0;
            wr_seen = 0;
        end else begin
            if (cfg_rd_en) rd_seen++;
            if (cfg_wr_en) wr_seen++;
            if (done) begin
                if (sb_q.size() == 0) begin
                    check("R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_item_t it;
                    string     t;
                    it = sb_q.pop_front();
                    t  = tag_q.pop_front();
                    check({t, " found"},   {20'h0, found_off}, {20'h0, it.found});
                    check({t, " prev"},    {20'h0, prev_off},  {20'h0, it.prev});
                    check({t, " err"},     {31'h0, err},       {31'h0, it.err});
                    check({t, " timeout"}, {31'h0, timeout},   {31'h0, it.to});
                    check({t, " reads"},   rd_seen,            it.reads);
                    check({t, " writes"},  wr_seen,            it.writes);
                end
                rd_seen = 0;
                wr_seen = 0;
                mon_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 busy",    {31'h0, busy},      32'h0);
        check("R11 done",    {31'h0, done},      32'h0);
        check("R11 found",   {20'h0, found_off}, 32'h0);
        check("R11 prev",    {20'h0, prev_off},  32'h0);
        check("R11 flags",   {30'h0, err, timeout}, 32'h0);
        check("R11 strobes", {30'h0, cfg_rd_en, cfg_wr_en}, 32'h0);

        put(12'h100, hdr(16'h0001, 4'h1, 12'h140));
        put(12'h140, hdr(16'h000B, 4'h2, 12'h200));
        put(12'h200, hdr(16'h0003, 4'h1, 12'h000));

        run_op("R1 R2 match at base",   16'h0001, 1'b0, 12'h0, 12'h100, 12'h000, 1'b0, 1'b0, 1, 0, 1'b0);
        run_op("R1 match second",       16'h000B, 1'b0, 12'h0, 12'h140, 12'h100, 1'b0, 1'b0, 2, 0, 1'b0);
        run_op("R1 R10 match third poked", 16'h0003, 1'b0, 12'h0, 12'h200, 12'h140, 1'b0, 1'b0, 3, 0, 1'b1);
        run_op("R4 not found",          16'h0099, 1'b0, 12'h0, 12'h000, 12'h200, 1'b0, 1'b0, 3, 0, 1'b0);
        run_op("R6 probe tail",         16'h0000, 1'b0, 12'h0, 12'h000, 12'h200, 1'b0, 1'b0, 3, 0, 1'b0);
        run_op("R7 append",             16'h0003, 1'b1, 12'h300, 12'h000, 12'h200, 1'b0, 1'b0, 3, 1, 1'b0);
        check("R7 tail word", mem[12'h200 >> 2], hdr(16'h0003, 4'h1, 12'h300));

        put(12'h300, hdr(16'h0007, 4'h1, 12'h000));
        run_op("R7 appended reachable", 16'h0007, 1'b0, 12'h0, 12'h300, 12'h200, 1'b0, 1'b0, 4, 0, 1'b0);
        run_op("R8 misaligned append",  16'h0000, 1'b1, 12'h302, 12'h000, 12'h300, 1'b1, 1'b0, 4, 0, 1'b0);
        check("R8 tail untouched", mem[12'h300 >> 2], hdr(16'h0007, 4'h1, 12'h000));

        put(12'h300, hdr(16'h0007, 4'h1, 12'hFF8));
        put(12'hFF8, hdr(16'h0022, 4'h1, 12'h000));
        run_op("R5 top boundary legal", 16'h0022, 1'b0, 12'h0, 12'hFF8, 12'h300, 1'b0, 1'b0, 5, 0, 1'b0);

        put(12'h300, hdr(16'h0007, 4'h1, 12'hFFC));
        run_op("R5 pointer above window", 16'h0055, 1'b0, 12'h0, 12'h000, 12'h300, 1'b1, 1'b0, 4, 0, 1'b0);

        put(12'h100, hdr(16'h0001, 4'h1, 12'h080));
        run_op("R5 pointer below window", 16'h0009, 1'b0, 12'h0, 12'h000, 12'h100, 1'b1, 1'b0, 1, 0, 1'b0);

        put(12'h100, hdr(16'h0005, 4'h1, 12'h100));
        run_op("R9 self loop timeout",  16'h0009, 1'b0, 12'h0, 12'h000, 12'h100, 1'b0, 1'b1, MAX_HOPS, 0, 1'b0);

        put(12'h100, 32'h0);
        run_op("R3 empty chain",        16'h0001, 1'b0, 12'h0, 12'h000, 12'h000, 1'b0, 1'b0, 1, 0, 1'b0);
        run_op("R3 R7 append on empty", 16'h0000, 1'b1, 12'h300, 12'h000, 12'h000, 1'b0, 1'b0, 1, 0, 1'b0);
        check("R3 base still empty", mem[12'h100 >> 2], 32'h0);

        report();
        $finish;
    end

endmodule